// File: doc/BRIEF.md
# Register Write-Protect Gate

This block sits on the 32-bit write bus of a memory-mapped register file and stops stray software writes from changing it. It holds a single protect flag. While the flag is set, every write aimed at a register the gate does not own is dropped before it reaches the register file, and a sticky error flag records the attempt. Reads are never held back. The gate merges its own two flags into the read data at their fixed bit positions. Its key registers always read as zero.

Software changes the protect flag by writing three key words in a fixed order to two key registers. That earns permission for exactly one control-register write, and the new flag value comes from bit 1 of that write. The key is required in both directions, so protection can be neither set nor cleared without it, even while it is already off. Any write that breaks the order, or carries a wrong key word, sends the tracker back to its start. The permission is used up by the next write of any kind.

Top module: `reg_wp_gate`

## Requirements
- R1: After a synchronous active-low reset, the protect flag is 1, the error flag is 0 and any key progress or held permission is gone.
- R2: The key is 0x7123 written to the key-A register (offset 0x18), then 0x812A written to the key-B register (offset 0x1C), then 0xBEE1 written to key-A again. The control write that follows (offset 0x00) loads the protect flag from data bit 1, and the new value is visible one cycle after that write.
- R3: A control write made without a freshly completed key leaves the protect flag unchanged. This holds whether the flag is 0 or 1.
- R4: While the protect flag is 1, writes to any offset other than 0x18, 0x1C and 0x2C are not forwarded (fwd_wr_en stays 0). The single exception is a control write that holds permission.
- R5: While the protect flag is 0, writes to offsets other than 0x18, 0x1C and 0x2C are forwarded in the same cycle with address and data unchanged.
- R6: A write dropped under R4 sets the error flag one cycle later. The flag stays set through idle cycles, later writes and key writes until it is cleared.
- R7: A write to the status register (offset 0x2C) with data bit 1 set clears the error flag on the next cycle. The same write with bit 1 clear leaves the flag as it is.
- R8: A wrong key word, or a write to any other register in the middle of the key, returns the tracker to its start. A write of 0x7123 to key-A always starts a new attempt.
- R9: Permission covers exactly one control write. A second control write does not change the protect flag.
- R10: Any write other than a control write, made while permission is held, cancels that permission.
- R11: Key-A and key-B read as 0. A control read returns ext_rd_data with bit 1 replaced by the protect flag. A status read returns ext_rd_data with bit 1 replaced by the error flag. All other offsets return ext_rd_data unchanged.
- R12: Writes to offsets 0x18, 0x1C and 0x2C are never forwarded and never raise the error flag, whatever the protect flag holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| fwd_wr_en | output | 1 | Write strobe passed to the register file |
| fwd_wr_addr | output | 8 | Forwarded write offset |
| fwd_wr_data | output | 32 | Forwarded write data |
| rd_addr | input | 8 | Read byte offset |
| ext_rd_data | input | 32 | Read data from the register file |
| rd_data | output | 32 | Read data with the gate's own fields merged in |
| prot_o | output | 1 | Current protect flag |
| err_o | output | 1 | Sticky blocked-write error flag |

## Verification
The key tracker is tried with the clean three-word key and with three kinds of broken key: a wrong word at the second step, a foreign write in the middle, and a doubled first word. These separate a tracker that truly resets from one that only waits for the right words to show up eventually, and they show that a first word restarts the count. Permission is tested by following a completed key with two control writes in a row, and again by putting an ordinary write between the key and the control write. This shows the permission being used up as well as cancelled. The forwarding filter is run with protection both on and off, with writes to ordinary offsets, to the control register and to the gate's own registers. This separates blocking by address from blocking by protect state. It also shows that the error flag rises only when a write is actually dropped. Finally, a reset applied while permission is held shows that no permission survives reset.

// File: rtl/wpg_pkg.sv
// Package for the register write-protect gate.
// Holds the default register offsets, the key words and the tracker state type.
// Assumes a 32-bit data path and byte offsets that fit in 8 bits.
package wpg_pkg;

    localparam logic [7:0]  OFS_CTRL  = 8'h00;
    localparam logic [7:0]  OFS_KEYA  = 8'h18;
    localparam logic [7:0]  OFS_KEYB  = 8'h1C;
    localparam logic [7:0]  OFS_STAT  = 8'h2C;

    localparam logic [31:0] KEY_WORD1 = 32'h0000_7123;
    localparam logic [31:0] KEY_WORD2 = 32'h0000_812A;
    localparam logic [31:0] KEY_WORD3 = 32'h0000_BEE1;

    typedef enum logic [1:0] {
        KS_IDLE  = 2'd0,
        KS_ONE   = 2'd1,
        KS_TWO   = 2'd2,
        KS_GRANT = 2'd3
    } key_state_e;

endpackage

// File: rtl/wpg_key_tracker.sv
// Key tracker: follows the three-write key on the write bus and holds
// one-shot permission (grant) once the key is complete.
// Assumes at most one write per cycle. Any write consumes or cancels grant.
module wpg_key_tracker
    import wpg_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 32,
    parameter logic [7:0]  KEYA_OFS = OFS_KEYA,
    parameter logic [7:0]  KEYB_OFS = OFS_KEYB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              grant
);

    localparam logic [ADDR_W-1:0] A_KEYA = ADDR_W'(KEYA_OFS);
    localparam logic [ADDR_W-1:0] A_KEYB = ADDR_W'(KEYB_OFS);
    localparam logic [DATA_W-1:0] W1 = DATA_W'(KEY_WORD1);
    localparam logic [DATA_W-1:0] W2 = DATA_W'(KEY_WORD2);
    localparam logic [DATA_W-1:0] W3 = DATA_W'(KEY_WORD3);

    key_state_e state_q, state_d;

    logic hit_w1, hit_w2, hit_w3;

    // Decode which key step, if any, the current write matches.
    always_comb begin
        hit_w1 = wr_en && (wr_addr == A_KEYA) && (wr_data == W1);
        hit_w2 = wr_en && (wr_addr == A_KEYB) && (wr_data == W2);
        hit_w3 = wr_en && (wr_addr == A_KEYA) && (wr_data == W3);
    end

    // Next-state: advance on the expected step, restart on word one, else idle.
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (hit_w1)
                state_d = KS_ONE;
            else if (state_q == KS_ONE && hit_w2)
                state_d = KS_TWO;
            else if (state_q == KS_TWO && hit_w3)
                state_d = KS_GRANT;
            else
                state_d = KS_IDLE;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= KS_IDLE;
        else
            state_q <= state_d;
    end

    assign grant = (state_q == KS_GRANT);

    // R2: grant can only appear right after the third key word.
    a_r2_grant_after_key3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> $past(wr_en && wr_addr == A_KEYA && wr_data == W3));

    // R9, R10: any write made while grant is held removes the grant.
    a_r9_grant_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && wr_en) |=> !grant);

    // R8: a wrong word at step two leaves the tracker short of step two.
    a_r8_bad_word_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KS_ONE && wr_en && wr_addr == A_KEYB && wr_data != W2)
        |=> (state_q == KS_IDLE));

endmodule

// File: rtl/wpg_wr_filter.sv
// Write filter: decides per write whether it is forwarded to the register
// file, dropped under protection, or consumed by the gate itself.
// Purely combinational. Assumes grant and prot come from registers.
module wpg_wr_filter
    import wpg_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  CTRL_OFS = OFS_CTRL,
    parameter logic [7:0]  KEYA_OFS = OFS_KEYA,
    parameter logic [7:0]  KEYB_OFS = OFS_KEYB,
    parameter logic [7:0]  STAT_OFS = OFS_STAT
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              prot,
    input  logic              grant,
    output logic              fwd,
    output logic              drop,
    output logic              ctrl_ok,
    output logic              stat_wr
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_KEYA = ADDR_W'(KEYA_OFS);
    localparam logic [ADDR_W-1:0] A_KEYB = ADDR_W'(KEYB_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    logic owned, is_ctrl;

    // Classify the target: a gate-owned register, the control register, or other.
    always_comb begin
        owned   = (wr_addr == A_KEYA) || (wr_addr == A_KEYB) || (wr_addr == A_STAT);
        is_ctrl = (wr_addr == A_CTRL);
    end

    // Forward, drop or consume the write.
    always_comb begin
        ctrl_ok = wr_en && is_ctrl && grant;
        stat_wr = wr_en && (wr_addr == A_STAT);
        fwd     = wr_en && !owned && (!prot || ctrl_ok);
        drop    = wr_en && !owned && prot && !ctrl_ok;
    end

endmodule

// File: rtl/wpg_flag_regs.sv
// Flag registers: hold the protect flag and the sticky error flag.
// The protect flag loads only on a permitted control write. The error flag
// is set by a dropped write and cleared by a write-one to the status bit.
module wpg_flag_regs #(
    parameter int   DATA_W   = 32,
    parameter int   PROT_BIT = 1,
    parameter int   ERR_BIT  = 1,
    parameter logic PROT_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_ok,
    input  logic              stat_wr,
    input  logic              drop,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prot,
    output logic              err
);

    logic clr_req;

    // A status write clears the error only when its error bit is one.
    assign clr_req = stat_wr && wr_data[ERR_BIT];

    // Protect flag: changes only on a permitted control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prot <= PROT_RST;
        else if (ctrl_ok)
            prot <= wr_data[PROT_BIT];
    end

    // Error flag: set wins over clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (drop)
            err <= 1'b1;
        else if (clr_req)
            err <= 1'b0;
    end

    // R3: without a permitted control write the protect flag holds.
    a_r3_prot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_ok |=> $stable(prot));

    // R6: a dropped write leaves the error flag set.
    a_r6_drop_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> err);

    // R6: the error flag only falls on a clearing status write.
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr_req) |=> err);

    // R7: a clearing status write with no drop clears the flag.
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !drop) |=> !err);

endmodule

// File: rtl/wpg_rd_mux.sv
// Read merge: overlays the gate's flags onto register-file read data and
// zeroes the key registers. Purely combinational. Reads are never blocked.
module wpg_rd_mux
    import wpg_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter int          PROT_BIT = 1,
    parameter int          ERR_BIT  = 1,
    parameter logic [7:0]  CTRL_OFS = OFS_CTRL,
    parameter logic [7:0]  KEYA_OFS = OFS_KEYA,
    parameter logic [7:0]  KEYB_OFS = OFS_KEYB,
    parameter logic [7:0]  STAT_OFS = OFS_STAT
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] ext_rd_data,
    input  logic              prot,
    input  logic              err,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_KEYA = ADDR_W'(KEYA_OFS);
    localparam logic [ADDR_W-1:0] A_KEYB = ADDR_W'(KEYB_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    // Select the read value per address.
    always_comb begin
        rd_data = ext_rd_data;
        if (rd_addr == A_KEYA || rd_addr == A_KEYB)
            rd_data = '0;
        else if (rd_addr == A_CTRL)
            rd_data[PROT_BIT] = prot;
        else if (rd_addr == A_STAT)
            rd_data[ERR_BIT] = err;
    end

endmodule

// File: rtl/reg_wp_gate.sv
// Register write-protect gate, top level.
// Sits between a register write bus and the register file. It forwards,
// drops or consumes each write, owns the protect and error flags, and merges
// them into read data. Assumes at most one write per cycle and a
// synchronous active-low reset.
module reg_wp_gate
    import wpg_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter int          PROT_BIT = 1,
    parameter int          ERR_BIT  = 1,
    parameter logic        PROT_RST = 1'b1,
    parameter logic [7:0]  CTRL_OFS = OFS_CTRL,
    parameter logic [7:0]  KEYA_OFS = OFS_KEYA,
    parameter logic [7:0]  KEYB_OFS = OFS_KEYB,
    parameter logic [7:0]  STAT_OFS = OFS_STAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              fwd_wr_en,
    output logic [ADDR_W-1:0] fwd_wr_addr,
    output logic [DATA_W-1:0] fwd_wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] ext_rd_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              prot_o,
    output logic              err_o
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_KEYA = ADDR_W'(KEYA_OFS);
    localparam logic [ADDR_W-1:0] A_KEYB = ADDR_W'(KEYB_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    logic grant, prot, err;
    logic fwd, drop, ctrl_ok, stat_wr;

    wpg_key_tracker #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .KEYA_OFS(KEYA_OFS), .KEYB_OFS(KEYB_OFS)
    ) u_tracker (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .grant(grant)
    );

    wpg_wr_filter #(
        .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .KEYA_OFS(KEYA_OFS),
        .KEYB_OFS(KEYB_OFS), .STAT_OFS(STAT_OFS)
    ) u_filter (
        .wr_en(wr_en), .wr_addr(wr_addr), .prot(prot), .grant(grant),
        .fwd(fwd), .drop(drop), .ctrl_ok(ctrl_ok), .stat_wr(stat_wr)
    );

    wpg_flag_regs #(
        .DATA_W(DATA_W), .PROT_BIT(PROT_BIT), .ERR_BIT(ERR_BIT), .PROT_RST(PROT_RST)
    ) u_flags (
        .clk(clk), .rst_n(rst_n),
        .ctrl_ok(ctrl_ok), .stat_wr(stat_wr), .drop(drop), .wr_data(wr_data),
        .prot(prot), .err(err)
    );

    wpg_rd_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_BIT(PROT_BIT), .ERR_BIT(ERR_BIT),
        .CTRL_OFS(CTRL_OFS), .KEYA_OFS(KEYA_OFS), .KEYB_OFS(KEYB_OFS), .STAT_OFS(STAT_OFS)
    ) u_rdmux (
        .rd_addr(rd_addr), .ext_rd_data(ext_rd_data), .prot(prot), .err(err),
        .rd_data(rd_data)
    );

    // Drive the forwarded bus; address and data pass through unchanged.
    always_comb begin
        fwd_wr_en   = fwd;
        fwd_wr_addr = wr_addr;
        fwd_wr_data = wr_data;
        prot_o      = prot;
        err_o       = err;
    end

    // R4: under protection only a permitted control write gets through.
    a_r4_locked_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_wr_en && prot_o) |-> (grant && wr_addr == A_CTRL));

    // R12: gate-owned registers never reach the register file.
    a_r12_owned_not_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_wr_en |-> (wr_addr != A_KEYA && wr_addr != A_KEYB && wr_addr != A_STAT));

    // R11: key registers always read as zero.
    a_r11_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_KEYA || rd_addr == A_KEYB) |-> (rd_data == '0));

    // R5: with protection off every non-owned write is forwarded.
    a_r5_open_forwards: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !prot_o && wr_addr != A_KEYA && wr_addr != A_KEYB && wr_addr != A_STAT)
        |-> fwd_wr_en);

endmodule

// File: tb/reg_wp_gate_tb.sv
// Bench for reg_wp_gate: a vector table walked by one loop, then directed
// tests for reads, reset with permission held, and idle stickiness.
module reg_wp_gate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        fwd_wr_en;
    logic [7:0]  fwd_wr_addr;
    logic [31:0] fwd_wr_data;
    logic [7:0]  rd_addr = '0;
    logic [31:0] ext_rd_data = '0;
    logic [31:0] rd_data;
    logic        prot_o, err_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    reg_wp_gate u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fwd_wr_en(fwd_wr_en), .fwd_wr_addr(fwd_wr_addr), .fwd_wr_data(fwd_wr_data),
        .rd_addr(rd_addr), .ext_rd_data(ext_rd_data), .rd_data(rd_data),
        .prot_o(prot_o), .err_o(err_o)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic [31:0] d;
        logic        f;   // expected forward
        logic        p;   // expected protect flag after the write
        logic        e;   // expected error flag after the write
        logic [3:0]  r;   // requirement number for messages
    } vec_t;

    localparam int NV = 44;
    localparam vec_t VECS [NV] = '{
        '{8'h24, 32'h5,     1'b0, 1'b1, 1'b1, 4'd4},  // R4 R6 drop under protection
        '{8'h2C, 32'h0,     1'b0, 1'b1, 1'b1, 4'd7},  // R7 bit1 clear: no effect
        '{8'h2C, 32'h2,     1'b0, 1'b1, 1'b0, 4'd7},  // R7 clear
        '{8'h00, 32'h0,     1'b0, 1'b1, 1'b1, 4'd3},  // R3 ctrl without key
        '{8'h2C, 32'h2,     1'b0, 1'b1, 1'b0, 4'd7},
        '{8'h18, 32'h7123,  1'b0, 1'b1, 1'b0, 4'd12}, // R12 key writes pass under lock
        '{8'h1C, 32'h812A,  1'b0, 1'b1, 1'b0, 4'd12},
        '{8'h18, 32'hBEE1,  1'b0, 1'b1, 1'b0, 4'd12},
        '{8'h00, 32'h0,     1'b1, 1'b0, 1'b0, 4'd2},  // R2 unlock clears flag
        '{8'h24, 32'h55,    1'b1, 1'b0, 1'b0, 4'd5},  // R5 forwarded when open
        '{8'h00, 32'h2,     1'b1, 1'b0, 1'b0, 4'd3},  // R3 no key while open
        '{8'h18, 32'h7123,  1'b0, 1'b0, 1'b0, 4'd8},  // R8 wrong second word
        '{8'h1C, 32'h1234,  1'b0, 1'b0, 1'b0, 4'd8},
        '{8'h18, 32'hBEE1,  1'b0, 1'b0, 1'b0, 4'd8},
        '{8'h00, 32'h2,     1'b1, 1'b0, 1'b0, 4'd8},
        '{8'h18, 32'h7123,  1'b0, 1'b0, 1'b0, 4'd8},  // R8 doubled first word restarts
        '{8'h18, 32'h7123,  1'b0, 1'b0, 1'b0, 4'd8},
        '{8'h1C, 32'h812A,  1'b0, 1'b0, 1'b0, 4'd8},
        '{8'h18, 32'hBEE1,  1'b0, 1'b0, 1'b0, 4'd8},
        '{8'h00, 32'h2,     1'b1, 1'b1, 1'b0, 4'd8},
        '{8'h18, 32'h7123,  1'b0, 1'b1, 1'b0, 4'd2},
        '{8'h1C, 32'h812A,  1'b0, 1'b1, 1'b0, 4'd2},
        '{8'h18, 32'hBEE1,  1'b0, 1'b1, 1'b0, 4'd2},
        '{8'h00, 32'h0,     1'b1, 1'b0, 1'b0, 4'd9},  // R9 first use
        '{8'h00, 32'h2,     1'b1, 1'b0, 1'b0, 4'd9},  // R9 second use refused
        '{8'h18, 32'h7123,  1'b0, 1'b0, 1'b0, 4'd10},
        '{8'h1C, 32'h812A,  1'b0, 1'b0, 1'b0, 4'd10},
        '{8'h18, 32'hBEE1,  1'b0, 1'b0, 1'b0, 4'd10},
        '{8'h24, 32'h1,     1'b1, 1'b0, 1'b0, 4'd10}, // R10 other write cancels
        '{8'h00, 32'h2,     1'b1, 1'b0, 1'b0, 4'd10},
        '{8'h18, 32'h7123,  1'b0, 1'b0, 1'b0, 4'd8},  // R8 foreign write mid-key
        '{8'h24, 32'h0,     1'b1, 1'b0, 1'b0, 4'd8},
        '{8'h1C, 32'h812A,  1'b0, 1'b0, 1'b0, 4'd8},
        '{8'h18, 32'hBEE1,  1'b0, 1'b0, 1'b0, 4'd8},
        '{8'h00, 32'h2,     1'b1, 1'b0, 1'b0, 4'd8},
        '{8'h18, 32'h7123,  1'b0, 1'b0, 1'b0, 4'd2},
        '{8'h1C, 32'h812A,  1'b0, 1'b0, 1'b0, 4'd2},
        '{8'h18, 32'hBEE1,  1'b0, 1'b0, 1'b0, 4'd2},
        '{8'h00, 32'h2,     1'b1, 1'b1, 1'b0, 4'd2},  // R2 relock
        '{8'h00, 32'h0,     1'b0, 1'b1, 1'b1, 4'd4},  // R4 ctrl blocked
        '{8'h1C, 32'h812A,  1'b0, 1'b1, 1'b1, 4'd6},  // R6 sticky over key write
        '{8'h24, 32'h9,     1'b0, 1'b1, 1'b1, 4'd6},
        '{8'h2C, 32'h2,     1'b0, 1'b1, 1'b0, 4'd7},
        '{8'h2C, 32'h0,     1'b0, 1'b1, 1'b0, 4'd7}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // One write: check forwarding mid-cycle, flags after the edge.
    task automatic do_wr(input logic [7:0] a, input logic [31:0] d,
                         input logic ef, input logic ep, input logic ee, input int r);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        #1;
        chk({31'b0, fwd_wr_en}, {31'b0, ef}, $sformatf("R%0d fwd a=%h", r, a));
        if (ef) begin
            chk({24'b0, fwd_wr_addr}, {24'b0, a}, $sformatf("R%0d fwd addr", r));
            chk(fwd_wr_data, d, $sformatf("R%0d fwd data", r));
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        chk({31'b0, prot_o}, {31'b0, ep}, $sformatf("R%0d prot a=%h", r, a));
        chk({31'b0, err_o}, {31'b0, ee}, $sformatf("R%0d err a=%h", r, a));
    endtask

    task automatic do_key();
        do_wr(8'h18, 32'h7123, 1'b0, prot_o, err_o, 2);
        do_wr(8'h1C, 32'h812A, 1'b0, prot_o, err_o, 2);
        do_wr(8'h18, 32'hBEE1, 1'b0, prot_o, err_o, 2);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] ext,
                          input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a; ext_rd_data = ext;
        #1;
        chk(rd_data, exp, $sformatf("R11 read a=%h", a));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk({31'b0, prot_o}, 32'd1, "R1 prot at reset");
        chk({31'b0, err_o}, 32'd0, "R1 err at reset");
        chk({31'b0, fwd_wr_en}, 32'd0, "R1 fwd idle");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            do_wr(VECS[i].a, VECS[i].d, VECS[i].f, VECS[i].p, VECS[i].e, int'(VECS[i].r));

        // R11 read merge, protect on and error clear here
        rd_chk(8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h0000_0000, 32'h0000_0002);
        rd_chk(8'h2C, 32'hFFFF_FFFF, 32'hFFFF_FFFD);
        rd_chk(8'h18, 32'hFFFF_FFFF, 32'h0000_0000);
        rd_chk(8'h1C, 32'hFFFF_FFFF, 32'h0000_0000);
        rd_chk(8'h24, 32'hA5A5_5A5A, 32'hA5A5_5A5A);

        // R6 stickiness across idle cycles, then R11 status read shows it
        do_wr(8'h30, 32'h1, 1'b0, 1'b1, 1'b1, 6);
        repeat (5) @(posedge clk);
        #1;
        chk({31'b0, err_o}, 32'd1, "R6 err after idle");
        rd_chk(8'h2C, 32'h0, 32'h0000_0002);
        do_wr(8'h2C, 32'h2, 1'b0, 1'b1, 1'b0, 7);

        // R1 reset while open and holding permission
        do_key();
        do_wr(8'h00, 32'h0, 1'b1, 1'b0, 1'b0, 2);
        rd_chk(8'h00, 32'h0, 32'h0);
        do_key();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk({31'b0, prot_o}, 32'd1, "R1 prot after reset");
        @(negedge clk);
        rst_n = 1'b1;
        do_wr(8'h00, 32'h0, 1'b0, 1'b1, 1'b1, 1);  // R1 permission gone

        finish_run();
    end

endmodule